// File: doc/BRIEF.md
# Triggered Chip Sequence Playback Controller

This block generates the read address for a chip sequence held in an external memory. The sequence is 98304 chips long by default. The controller moves forward by one address on every cycle where the chip-enable strobe is high. In free-running mode it repeats the sequence without end. In triggered mode it waits at address 0 until a trigger arrives. A trigger can be an edge on an asynchronous input, with the edge polarity selectable, or a one-cycle software strobe.

When a trigger is accepted, a programmable number of chips can pass before playback starts. A one-chip pulse marks every accepted trigger. In single-shot mode the sequence plays once and the block returns to the wait state. In retrigger mode a new trigger restarts the sequence during playback. After each accepted trigger, further triggers are ignored for a programmable number of chips.

Top module: `chipseq_player`

## Requirements
- R1: While reset is held, and after its release before any chip strobe, `addr` is 0 and `active` and `trig_out` are 0.
- R2: With `auto_mode`=1, the first chip strobe taken from the wait state asserts `active` with `addr` at 0. Each later strobe adds one to `addr`, and it wraps from SEQ_LEN-1 (98303 by default) to 0 without stopping. Triggers are ignored and `trig_out` stays 0.
- R3: `addr`, `active` and `trig_out` change only on clock edges where `chip_en` is 1.
- R4: `edge_fall`=0 selects rising edges of `trig_in` and `edge_fall`=1 selects falling edges. The opposite edge has no effect. `trig_in` passes through two synchronising flops, so an edge is accepted at the second chip strobe after it when strobes arrive every second clock.
- R5: An accepted trigger sets `trig_out` at its chip strobe. `trig_out` returns to 0 at the next strobe unless that strobe also accepts a trigger.
- R6: With `delay_chips`=D, `addr` is held at 0 after acceptance. `active` rises D strobes after the accepting strobe (at that strobe when D=0). From then on `addr` counts 0, 1, 2, and so on.
- R7: With `retrig_en`=0 and `auto_mode`=0, triggers during delay or playback are ignored. After address SEQ_LEN-1 the next strobe sets `addr` to 0 and `active` to 0, and the block waits.
- R8: With `retrig_en`=1, a trigger during delay or playback restarts the sequence from address 0 with the programmed delay. With `inhibit_chips`=I, triggers at the I strobes following an acceptance are ignored.
- R9: A one-cycle `sw_trig` pulse acts as a trigger edge without synchroniser latency. It is accepted at the strobe in its own cycle, or held until the next strobe if `chip_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | One-cycle chip strobe |
| auto_mode | input | 1 | Free-running repetition |
| retrig_en | input | 1 | Allow restart during playback |
| edge_fall | input | 1 | Trigger edge: 0 rising, 1 falling |
| trig_in | input | 1 | Asynchronous external trigger |
| sw_trig | input | 1 | Software trigger strobe |
| delay_chips | input | CNT_W | Chips from trigger to playback |
| inhibit_chips | input | CNT_W | Chips during which retriggers are ignored |
| addr | output | ADDR_W | Sequence memory address |
| active | output | 1 | Playback in progress |
| trig_out | output | 1 | One-chip pulse per accepted trigger |

## Verification
The assertions assume that `delay_chips`, `inhibit_chips` and the mode inputs stay stable while a trigger window is open. They also assume that `sw_trig` is a single-cycle pulse. The stimulus changes the configuration only while the block waits at address 0 with no window running, and it never holds `sw_trig` for more than one clock. External edges come from a single `trig_in` transition per test that stays put long enough to pass both synchroniser stages. The bench issues a chip strobe every second clock, so every register shows a stable state between strobes.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PLAY  = 2'd2
  } cs_state_e;
endpackage

// File: rtl/cs_trig_detect.sv
module cs_trig_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic edge_fall,
  input  logic sw_trig,
  input  logic consume,
  output logic req
);
  logic s1_q, s2_q, s3_q;
  logic pend_q, pend_n;
  logic evt;

  // two synchronising stages, third stage holds the previous value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= trig_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign evt = edge_fall ? (s3_q & ~s2_q) : (~s3_q & s2_q);

  always_comb begin
    pend_n = pend_q;
    if (consume)            pend_n = 1'b0;
    else if (evt | sw_trig) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_n;
  end

  assign req = pend_q | evt | sw_trig;

  // R4: a selected edge that lands between strobes must still be seen later
  a_r4_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !consume) |=> req);
endmodule

// File: rtl/cs_down_ctr.sv
module cs_down_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)               cnt_n = load_val;
    else if (cnt_q != '0)   cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (ce) cnt_q <= cnt_n;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

  // R6/R8: windows shrink by exactly one chip per strobe
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !load && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/cs_addr_ctr.sv
module cs_addr_ctr #(
  parameter int SEQ_LEN = 98304,
  localparam int ADDR_W = $clog2(SEQ_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SEQ_LEN - 1);

  logic [ADDR_W-1:0] addr_q, addr_n;

  always_comb begin
    addr_n = addr_q;
    if (clr)      addr_n = '0;
    else if (inc) addr_n = (addr_q == LAST) ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr_q <= '0;
    else if (ce) addr_q <= addr_n;
  end

  assign addr    = addr_q;
  assign at_last = (addr_q == LAST);

  // R2: address never leaves the stored sequence
  a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= LAST);
endmodule

// File: rtl/chipseq_player.sv
module chipseq_player #(
  parameter int SEQ_LEN = 98304,
  parameter int CNT_W   = 16,
  localparam int ADDR_W = $clog2(SEQ_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              auto_mode,
  input  logic              retrig_en,
  input  logic              edge_fall,
  input  logic              trig_in,
  input  logic              sw_trig,
  input  logic [CNT_W-1:0]  delay_chips,
  input  logic [CNT_W-1:0]  inhibit_chips,
  output logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic              trig_out
);
  import cs_pkg::*;

  cs_state_e   state_q, state_n;
  logic        req, accept;
  logic        addr_clr, addr_inc, at_last;
  logic        trig_q;
  logic [CNT_W-1:0] dly_cnt, inh_cnt;
  logic        dly_zero, inh_zero;

  cs_trig_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_in   (trig_in),
    .edge_fall (edge_fall),
    .sw_trig   (sw_trig),
    .consume   (chip_en),
    .req       (req)
  );

  cs_down_ctr #(.W(CNT_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (chip_en),
    .load     (accept),
    .load_val (delay_chips),
    .cnt      (dly_cnt),
    .zero     (dly_zero)
  );

  cs_down_ctr #(.W(CNT_W)) u_inh (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (chip_en),
    .load     (accept),
    .load_val (inhibit_chips),
    .cnt      (inh_cnt),
    .zero     (inh_zero)
  );

  cs_addr_ctr #(.SEQ_LEN(SEQ_LEN)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (chip_en),
    .clr     (addr_clr),
    .inc     (addr_inc),
    .addr    (addr),
    .at_last (at_last)
  );

  assign accept = chip_en & ~auto_mode & req &
                  ((state_q == ST_IDLE) | (retrig_en & inh_zero));

  always_comb begin
    state_n  = state_q;
    addr_clr = 1'b0;
    addr_inc = 1'b0;
    if (accept) begin
      state_n  = (delay_chips == '0) ? ST_PLAY : ST_DELAY;
      addr_clr = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (auto_mode) state_n = ST_PLAY;
        ST_DELAY: if (dly_cnt == CNT_W'(1) || dly_zero) state_n = ST_PLAY;
        ST_PLAY: begin
          addr_inc = 1'b1;
          if (at_last && !auto_mode) state_n = ST_IDLE;
        end
        default:  state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trig_q  <= 1'b0;
    end else if (chip_en) begin
      state_q <= state_n;
      trig_q  <= accept;
    end
  end

  assign active   = (state_q == ST_PLAY);
  assign trig_out = trig_q;

  // R2: free-running playback wraps to the first chip
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && auto_mode && active && at_last) |=> (addr == '0));

  // R3: nothing moves between chip strobes
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> ($stable(addr) && $stable(trig_out) && $stable(state_q)));

  // R6: address parked at zero during the start delay
  a_r6_delay_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DELAY) |-> (addr == '0));

  // R7: single-shot mode ignores triggers while busy
  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !retrig_en && state_q != ST_IDLE) |=> !trig_out);

  // R8: no trigger pulse while the inhibit window is open
  a_r8_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && retrig_en && !inh_zero && state_q != ST_IDLE) |=> !trig_out);

  // R5: the pulse only starts on a chip strobe
  a_r5_pulse_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> $past(chip_en));
endmodule

// File: tb/sim_chipseq_player.sv
module sim_chipseq_player;
  localparam int SEQ = 12;
  localparam int CW  = 4;
  localparam int AW  = $clog2(SEQ);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, chip_en, auto_mode, retrig_en, edge_fall, trig_in, sw_trig;
  logic [CW-1:0] delay_chips, inhibit_chips;
  logic [AW-1:0] addr;
  logic          active, trig_out;

  chipseq_player #(.SEQ_LEN(SEQ), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .auto_mode(auto_mode),
    .retrig_en(retrig_en), .edge_fall(edge_fall), .trig_in(trig_in),
    .sw_trig(sw_trig), .delay_chips(delay_chips), .inhibit_chips(inhibit_chips),
    .addr(addr), .active(active), .trig_out(trig_out)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic outs(input string tag, input int a, input int act_e, input int tr);
    chk({tag, " addr"},     int'(addr),     a);
    chk({tag, " active"},   int'(active),   act_e);
    chk({tag, " trig_out"}, int'(trig_out), tr);
  endtask

  task automatic tick(input logic ce, input logic sw);
    @(negedge clk);
    chip_en = ce;
    sw_trig = sw;
    @(posedge clk);
    #2;
  endtask

  // one idle clock then one strobe clock
  task automatic chip(input logic sw_idle, input logic sw_chip);
    tick(1'b0, sw_idle);
    tick(1'b1, sw_chip);
  endtask

  task automatic drain();
    int g = 0;
    while (active && g < 40) begin
      chip(1'b0, 1'b0);
      g++;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chip_en = 1'b0; auto_mode = 1'b0; retrig_en = 1'b0;
    edge_fall = 1'b0; trig_in = 1'b0; sw_trig = 1'b0;
    delay_chips = '0; inhibit_chips = '0;
    repeat (3) @(posedge clk);
    #2;
    outs("R1 in reset", 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    outs("R1 after reset", 0, 0, 0);

    // R4/R6: rising edge, delay sweep; falling edge ignored
    for (int d = 0; d < 4; d++) begin
      delay_chips = CW'(d);
      trig_in = 1'b1;
      chip(1'b0, 1'b0);
      chip(1'b0, 1'b0);
      outs("R4 R5 rising accept", 0, (d == 0) ? 1 : 0, 1);
      for (int j = 1; j <= d + 3; j++) begin
        chip(1'b0, 1'b0);
        outs("R6 delay", (j >= d) ? j - d : 0, (j >= d) ? 1 : 0, 0);
      end
      drain();
      trig_in = 1'b0;
      for (int k = 0; k < 3; k++) begin
        chip(1'b0, 1'b0);
        outs("R4 opposite edge", 0, 0, 0);
      end
    end

    // R4: falling polarity
    edge_fall = 1'b1;
    delay_chips = '0;
    trig_in = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chip(1'b0, 1'b0);
      outs("R4 rising ignored in falling mode", 0, 0, 0);
    end
    trig_in = 1'b0;
    chip(1'b0, 1'b0);
    chip(1'b0, 1'b0);
    outs("R4 falling accept", 0, 1, 1);
    drain();
    edge_fall = 1'b0;

    // R7/R9/R3: single-shot playback, software triggers while busy ignored
    chip(1'b0, 1'b1);
    outs("R9 sw accept", 0, 1, 1);
    for (int n = 1; n <= SEQ; n++) begin
      chip(1'b0, (n == 5) ? 1'b1 : 1'b0);
      outs("R7 single shot", (n < SEQ) ? n : 0, (n < SEQ) ? 1 : 0, 0);
      if (n == 3) begin
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        outs("R3 hold between strobes", 3, 1, 0);
      end
    end
    for (int k = 0; k < 2; k++) begin
      chip(1'b0, 1'b0);
      outs("R7 waits at zero", 0, 0, 0);
    end

    // R9: software pulse between strobes is held
    chip(1'b1, 1'b0);
    outs("R9 pending sw", 0, 1, 1);
    drain();

    // R8: retrigger with inhibit sweep
    retrig_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      inhibit_chips = CW'(i);
      for (int t = 1; t <= 4; t++) begin
        chip(1'b0, 1'b1);
        outs("R8 first accept", 0, 1, 1);
        for (int m = 1; m < t; m++) chip(1'b0, 1'b0);
        chip(1'b0, 1'b1);
        if (t > i) outs("R8 restart", 0, 1, 1);
        else       outs("R8 inhibited", t, 1, 0);
        drain();
      end
    end

    // R8/R6: retrigger with a start delay
    inhibit_chips = '0;
    delay_chips = CW'(2);
    chip(1'b0, 1'b1);
    for (int j = 1; j <= 4; j++) chip(1'b0, 1'b0);
    outs("R6 play before restart", 2, 1, 0);
    chip(1'b0, 1'b1);
    outs("R8 restart into delay", 0, 0, 1);
    chip(1'b0, 1'b0);
    outs("R8 delay chip 1", 0, 0, 0);
    chip(1'b0, 1'b0);
    outs("R8 delay done", 0, 1, 0);
    drain();

    // R2: free running with wrap, then back to single shot
    retrig_en = 1'b0;
    delay_chips = '0;
    auto_mode = 1'b1;
    chip(1'b0, 1'b1);
    outs("R2 auto start", 0, 1, 0);
    for (int n = 1; n < 30; n++) begin
      chip(1'b0, (n % 7 == 0) ? 1'b1 : 1'b0);
      outs("R2 auto wrap", n % SEQ, 1, 0);
    end
    auto_mode = 1'b0;
    for (int k = (29 % SEQ) + 1; k < SEQ; k++) begin
      chip(1'b0, 1'b0);
      outs("R2 R7 finish after auto", k, 1, 0);
    end
    chip(1'b0, 1'b0);
    outs("R7 stop after auto", 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule